// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This block monitors eight external input lines. On each line, an edge whose direction is chosen per channel sets a sticky pending bit. Each pending bit stays set until software clears it. The pending bits are masked by a per-channel enable. All masked bits are ORed into a single level interrupt request to the processor. Because the request is a level, it stays high and the interrupt repeats until every enabled pending bit has been cleared.

Software reaches three 8-bit registers over a small bus. The bus has a 2-bit address, a write strobe with 8-bit write data, and combinational 8-bit read data. The three registers are the pending bits, the enables and the edge directions. Writing a 1 to a pending bit raises it just as a pin edge would. The enable register has no side effects on its own, so it can hold general-purpose data.

Top module: `xirq_edge_unit`

## Requirements
- R1: On reset, the pending register (address 0), the enable register (address 1) and the polarity register (address 2) all read 00h, and `irq` is 0. Address 3 reads 00h.
- R2: Each pin passes through a two-flop synchroniser before edge detection. With polarity bit n at 0, a 0-to-1 change on `pin_i[n]` sets pending bit n. It becomes visible on `rd_data` in the third clock edge after the change is sampled, not earlier.
- R3: With polarity bit n at 1, a 1-to-0 change on `pin_i[n]` sets pending bit n. A change in the opposite direction leaves the bit unchanged.
- R4: A pending bit stays set until software writes 0 to it or reset occurs. Further pin activity never clears it.
- R5: A write to address 0 loads the pending register from `wr_data` in the next cycle. Writing 1 sets a bit and writing 0 clears it.
- R6: When a detected edge on channel n and a write of 0 to pending bit n fall in the same cycle, the bit ends up set.
- R7: `irq` is 1 exactly when (pending AND enable) is non-zero. It follows register changes in the same cycle, with no further delay.
- R8: The enable register (address 1) and the polarity register (address 2) read back exactly what was last written.
- R9: Writing the polarity register never sets a pending bit by itself, whatever the pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 8 | Asynchronous external interrupt lines |
| addr | input | 2 | Register select: 0 pending, 1 enable, 2 polarity |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a clearing write to a pending bit in the same cycle that a synchronised edge reaches the detector. This edge arrives two flops after the pin change, so the bench counts that delay exactly. It changes the pin and then issues the clearing write in the exact cycle the detector sees the edge. It also covers the cases one cycle earlier and one cycle later. Polarity and the irq mask are then swept over all 256 enable patterns and all eight channels in both edge directions.

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] pin_i,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [CH-1:0] wr_data,
  output logic [CH-1:0] rd_data,
  output logic          irq
);
  localparam logic [1:0] A_PEND = 2'd0, A_ENA = 2'd1, A_POL = 2'd2;

  logic [CH-1:0] sync1, sync2, prev;
  logic [CH-1:0] pend, ena, pol;
  logic [CH-1:0] rise, fall, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;
  assign hit  = (rise & ~pol) | (fall & pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ena  <= '0;
      pol  <= '0;
    end else begin
      if (wr_en && addr == A_PEND) pend <= wr_data | hit;
      else                         pend <= pend | hit;
      if (wr_en && addr == A_ENA)  ena  <= wr_data;
      if (wr_en && addr == A_POL)  pol  <= wr_data;
    end
  end

  always_comb begin
    case (addr)
      A_PEND:  rd_data = pend;
      A_ENA:   rd_data = ena;
      A_POL:   rd_data = pol;
      default: rd_data = '0;
    endcase
  end

  assign irq = |(pend & ena);
endmodule

module xirq_edge_unit_chk #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    addr,
  input logic          wr_en,
  input logic [CH-1:0] wr_data,
  input logic [CH-1:0] pend,
  input logic [CH-1:0] ena,
  input logic [CH-1:0] hit,
  input logic          irq
);
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(pend & ena)));                                                 // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd0) |=> (pend & $past(pend)) == $past(pend));       // R4
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && hit == '0) |=> pend == $past(wr_data));        // R5
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (pend & $past(hit)) == $past(hit));                      // R6
  AST_ENA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> ena == $past(wr_data));                      // R8
endmodule

bind xirq_edge_unit xirq_edge_unit_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .pend(pend), .ena(ena), .hit(hit), .irq(irq));

// File: tb/xirq_edge_unit_bench.sv
module xirq_edge_unit_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pin_i = '0;
  logic [1:0] addr = '0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  xirq_edge_unit u_xirq_edge_unit (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  function automatic logic [7:0] rd(input logic [1:0] a);
    addr = a; return rd_data;
  endfunction

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #1; chk(req, rd_data, exp);
  endtask

  task automatic settle(); repeat (4) tick(); endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; #1;
    // R1 reset state
    rd_chk("R1", 2'd0, 8'h00);
    rd_chk("R1", 2'd1, 8'h00);
    rd_chk("R1", 2'd2, 8'h00);
    rd_chk("R1", 2'd3, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);

    // R8 readback sweep
    for (int v = 0; v < 256; v += 17) begin
      wr(2'd1, v[7:0]); rd_chk("R8", 2'd1, v[7:0]);
      wr(2'd2, ~v[7:0]); rd_chk("R8", 2'd2, ~v[7:0]);
    end
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R2 rising edge latency, per channel
    for (int n = 0; n < 8; n++) begin
      addr = 2'd0;
      pin_i[n] = 1'b1;
      tick(); tick();
      chk("R2", rd_data[n], 1'b0);
      tick();
      chk("R2", rd_data, 8'h01 << n);
      pin_i[n] = 1'b0; settle();
      chk("R4", rd_data, 8'h01 << n);
      wr(2'd0, 8'h00);
    end

    // R3 falling polarity: pins start high
    pin_i = 8'hFF; settle(); wr(2'd0, 8'h00);
    wr(2'd2, 8'hFF);
    rd_chk("R9", 2'd0, 8'h00);
    for (int n = 0; n < 8; n++) begin
      pin_i[n] = 1'b0; settle();
      rd_chk("R3", 2'd0, 8'h01 << n);
      pin_i[n] = 1'b1; settle();
      rd_chk("R3", 2'd0, 8'h01 << n);
      wr(2'd0, 8'h00);
    end
    // R9: toggling polarity with static pins sets nothing
    wr(2'd2, 8'h00); wr(2'd2, 8'hFF); wr(2'd2, 8'h00); settle();
    rd_chk("R9", 2'd0, 8'h00);
    pin_i = 8'h00; settle(); wr(2'd0, 8'h00);

    // R5 software load
    wr(2'd0, 8'hA5); rd_chk("R5", 2'd0, 8'hA5);
    wr(2'd0, 8'h3C); rd_chk("R5", 2'd0, 8'h3C);

    // R7 irq mask sweep over all enables
    for (int e = 0; e < 256; e++) begin
      wr(2'd1, e[7:0]);
      chk("R7", {7'd0, irq}, {7'd0, |(e[7:0] & 8'h3C)});
    end
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    chk("R7", {7'd0, irq}, 8'h00);

    // R6 race: pin change, edge reaches detector two edges later.
    for (int off = 0; off < 3; off++) begin
      pin_i[4] = 1'b1;
      tick();            // sync1
      if (off == 0) wr(2'd0, 8'h00); else tick();   // sync2 -> edge seen now
      if (off == 1) wr(2'd0, 8'h00);                // write coincides with edge
      else if (off == 2) begin tick(); wr(2'd0, 8'h00); end
      else tick();
      settle();
      rd_chk("R6", 2'd0, off == 2 ? 8'h00 : 8'h10);
      pin_i[4] = 1'b0; settle(); wr(2'd0, 8'h00);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule